// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter with Alarm Match

This block keeps wall-clock time and calendar date as a chain of packed-BCD counters. An external one-pulse-per-second strobe (`tick`) advances seconds. The carries then ripple through minutes, hours, day of week, day of month, month and a two-digit year. The hour counter runs in either 24-hour or 12-hour form. The mode flag and the afternoon flag sit inside the hour byte itself. Month lengths and leap Februaries are handled without host help.

A host reaches every counter and three alarm latches through a plain register port. Writes are addressed and take one cycle. Reads are combinational from `rd_addr`. There is no data stream, so there is no valid/ready handshake: a write is accepted in any cycle that `wr_en` is high, and it is never stalled. The alarm latches hold a seconds, minutes and hours target. When alarm matching is enabled and a tick leaves the time equal to the target, the block emits a one-cycle `alarm_hit` pulse. A run control freezes all counting while writes stay possible.

Top module: `rtc_calendar_core`

## Requirements
- R1: Seconds and minutes count 00..59 in packed BCD (tens in bits 6:4, units in bits 3:0). A tick at second 59 wraps seconds to 00 and advances minutes. Minute 59 plus that carry wraps to 00 and advances hours.
- R2: With hour bit 7 = 0 (24-hour form), hours count 00..23 in BCD in bits 5:0. A carry at 23 wraps to 00 and advances the day.
- R3: With hour bit 7 = 1 (12-hour form), bit 5 is the afternoon flag (1 = PM) and bits 4:0 hold 01..12 in BCD. 11 goes to 12 and inverts the flag, and 12 goes to 01 with the flag kept. Only 11 PM to 12 AM (0xB1 to 0x92) advances the day.
- R4: Day of week counts 01..07 and goes from 07 back to 01 on every day advance.
- R5: The date wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, 31 for the other months, and 29 for month 02 when the year value is a multiple of 4 (28 otherwise). Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R6: Register offsets from the base (default 0x20): 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 8 alarm seconds, 9 alarm minutes, 10 alarm hours. Offset 7, the alarm latches and any other address read 0x00. Bits that a register does not store read 0 (for example, writing 0xD5 to seconds reads back 0x55, and writing 0xC5 to hours reads back 0x85).
- R7: The alarm latches are write-only. The alarm hour is compared on bits 5:0 only, so its bits 7:6 are ignored, and bit 5 serves as the PM flag in 12-hour form.
- R8: `alarm_hit` is high for exactly the one cycle after a tick advance that leaves seconds, minutes and hours (bits 5:0) equal to the latches, and only while `alarm_en` is high. A host write to a time register alone never raises it.
- R9: While `run` is low, ticks are ignored and all counters hold. Host writes still take effect.
- R10: A host write to a counter in the same cycle as a tick wins for that counter. The tick still advances the other counters from their old values.
- R11: After reset, the time is 00:00:00 in 24-hour form, day of week 01, date 01, month 01, year 00, all alarm latches are 0 and `alarm_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe, once per second |
| run | input | 1 | 1 = counting enabled, 0 = frozen |
| alarm_en | input | 1 | Enables the alarm match pulse |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | ADDR_W | Host read address |
| rd_data | output | 8 | Combinational read data |
| alarm_hit | output | 1 | One-cycle alarm match pulse |

## Verification
A wrong carry condition or a wrong digit limit shows up on the read port right after the first tick that crosses the affected boundary. For example, a date that reads 29 after February of a non-leap year shows the error within one tick of that boundary. A stale or corrupted alarm latch cannot be read, so its only symptom is a missing or extra `alarm_hit` in the cycle after the matching tick. The bench therefore sets up each boundary one second early and checks both the counters and the pulse immediately after a single tick.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  typedef logic [7:0] bcd8_t;

  localparam int unsigned REG_COUNT = 11;
  localparam int unsigned OFS_SEC   = 0;
  localparam int unsigned OFS_MIN   = 1;
  localparam int unsigned OFS_HOUR  = 2;
  localparam int unsigned OFS_DOW   = 3;
  localparam int unsigned OFS_DATE  = 4;
  localparam int unsigned OFS_MON   = 5;
  localparam int unsigned OFS_YEAR  = 6;
  localparam int unsigned OFS_ASEC  = 8;
  localparam int unsigned OFS_AMIN  = 9;
  localparam int unsigned OFS_AHOUR = 10;

  // next BCD value, no wrap limit
  function automatic bcd8_t bcd_inc(input bcd8_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // multiple of four: 10*t + u == 2*t + u (mod 4)
  function automatic logic is_leap(input bcd8_t y);
    logic [3:0] s;
    s = y[3:0] + {2'b00, y[4], 1'b0};
    return (s[1:0] == 2'b00);
  endfunction

  function automatic bcd8_t month_len(input bcd8_t m, input bcd8_t y);
    case (m)
      8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // keep only the hour bits that the chosen form uses
  function automatic bcd8_t hour_mask(input bcd8_t d);
    if (d[7]) return {2'b10, d[5], d[4:0]};
    return {2'b00, d[5:0]};
  endfunction
endpackage

// File: rtl/rtc_hms_chain.sv
module rtc_hms_chain
  import rtc_cal_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  logic  wr_sec,
  input  logic  wr_min,
  input  logic  wr_hour,
  input  bcd8_t wdata,
  output bcd8_t sec,
  output bcd8_t min,
  output bcd8_t hour,
  output logic  day_carry
);
  logic  sec_wrap, min_wrap, hour_last;
  bcd8_t hour_nxt, inc12, inc24;

  assign sec_wrap  = (sec == 8'h59);
  assign min_wrap  = (min == 8'h59);
  assign hour_last = hour[7] ? (hour[5:0] == 6'h31) : (hour[5:0] == 6'h23);
  assign day_carry = adv && sec_wrap && min_wrap && hour_last;

  always_comb begin
    inc12 = bcd_inc({3'b000, hour[4:0]});
    inc24 = bcd_inc({2'b00, hour[5:0]});
    if (hour[7]) begin
      if (hour[4:0] == 5'h11)      hour_nxt = {2'b10, ~hour[5], 5'h12};
      else if (hour[4:0] == 5'h12) hour_nxt = {2'b10, hour[5], 5'h01};
      else                         hour_nxt = {2'b10, hour[5], inc12[4:0]};
    end else begin
      if (hour[5:0] == 6'h23)      hour_nxt = 8'h00;
      else                         hour_nxt = {2'b00, inc24[5:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec  <= 8'h00;
      min  <= 8'h00;
      hour <= 8'h00;
    end else begin
      if (wr_sec)   sec <= {1'b0, wdata[6:0]};
      else if (adv) sec <= sec_wrap ? 8'h00 : bcd_inc(sec);

      if (wr_min)               min <= {1'b0, wdata[6:0]};
      else if (adv && sec_wrap) min <= min_wrap ? 8'h00 : bcd_inc(min);

      if (wr_hour)                          hour <= hour_mask(wdata);
      else if (adv && sec_wrap && min_wrap) hour <= hour_nxt;
    end
  end
endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_cal_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  day_adv,
  input  logic  wr_dow,
  input  logic  wr_date,
  input  logic  wr_mon,
  input  logic  wr_year,
  input  bcd8_t wdata,
  output bcd8_t dow,
  output bcd8_t date,
  output bcd8_t mon,
  output bcd8_t year
);
  logic date_wrap, mon_wrap;

  assign date_wrap = (date >= month_len(mon, year));
  assign mon_wrap  = (mon == 8'h12);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dow  <= 8'h01;
      date <= 8'h01;
      mon  <= 8'h01;
      year <= 8'h00;
    end else begin
      if (wr_dow)       dow <= {5'b0, wdata[2:0]};
      else if (day_adv) dow <= (dow >= 8'h07) ? 8'h01 : dow + 8'd1;

      if (wr_date)      date <= {2'b0, wdata[5:0]};
      else if (day_adv) date <= date_wrap ? 8'h01 : bcd_inc(date);

      if (wr_mon)                    mon <= {3'b0, wdata[4:0]};
      else if (day_adv && date_wrap) mon <= mon_wrap ? 8'h01 : bcd_inc(mon);

      if (wr_year) year <= wdata;
      else if (day_adv && date_wrap && mon_wrap)
        year <= (year == 8'h99) ? 8'h00 : bcd_inc(year);
    end
  end
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_cal_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  logic  alarm_en,
  input  logic  wr_asec,
  input  logic  wr_amin,
  input  logic  wr_ahour,
  input  bcd8_t wdata,
  input  bcd8_t sec,
  input  bcd8_t min,
  input  bcd8_t hour,
  output logic  alarm_hit
);
  logic [6:0] a_sec, a_min;
  logic [5:0] a_hour;
  logic       adv_q, equal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_sec  <= '0;
      a_min  <= '0;
      a_hour <= '0;
      adv_q  <= 1'b0;
    end else begin
      if (wr_asec)  a_sec  <= wdata[6:0];
      if (wr_amin)  a_min  <= wdata[6:0];
      if (wr_ahour) a_hour <= wdata[5:0];
      adv_q <= adv;
    end
  end

  assign equal     = (sec[6:0] == a_sec) && (min[6:0] == a_min) && (hour[5:0] == a_hour);
  assign alarm_hit = adv_q && alarm_en && equal;
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned BASE_ADDR = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  logic              alarm_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              alarm_hit
);
  localparam int unsigned TIME_REGS = OFS_YEAR + 1;

  logic [REG_COUNT-1:0] wr_sel;
  logic [ADDR_W-1:0]    rd_off;
  logic                 tick_adv, time_wr, day_carry;
  bcd8_t t_sec, t_min, t_hour, t_dow, t_date, t_mon, t_year;

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_dec
    assign wr_sel[i] = wr_en && (wr_addr == ADDR_W'(BASE_ADDR + i));
  end

  assign tick_adv = tick && run;
  assign time_wr  = |wr_sel[TIME_REGS-1:0];

  rtc_hms_chain u_hms (
    .clk(clk), .rst_n(rst_n), .adv(tick_adv),
    .wr_sec(wr_sel[OFS_SEC]), .wr_min(wr_sel[OFS_MIN]), .wr_hour(wr_sel[OFS_HOUR]),
    .wdata(wr_data), .sec(t_sec), .min(t_min), .hour(t_hour), .day_carry(day_carry)
  );

  rtc_date_chain u_date (
    .clk(clk), .rst_n(rst_n), .day_adv(day_carry),
    .wr_dow(wr_sel[OFS_DOW]), .wr_date(wr_sel[OFS_DATE]),
    .wr_mon(wr_sel[OFS_MON]), .wr_year(wr_sel[OFS_YEAR]),
    .wdata(wr_data), .dow(t_dow), .date(t_date), .mon(t_mon), .year(t_year)
  );

  rtc_alarm_unit u_alarm (
    .clk(clk), .rst_n(rst_n), .adv(tick_adv), .alarm_en(alarm_en),
    .wr_asec(wr_sel[OFS_ASEC]), .wr_amin(wr_sel[OFS_AMIN]), .wr_ahour(wr_sel[OFS_AHOUR]),
    .wdata(wr_data), .sec(t_sec), .min(t_min), .hour(t_hour), .alarm_hit(alarm_hit)
  );

  assign rd_off = rd_addr - ADDR_W'(BASE_ADDR);

  always_comb begin
    case (rd_off)
      ADDR_W'(OFS_SEC):  rd_data = t_sec;
      ADDR_W'(OFS_MIN):  rd_data = t_min;
      ADDR_W'(OFS_HOUR): rd_data = t_hour;
      ADDR_W'(OFS_DOW):  rd_data = t_dow;
      ADDR_W'(OFS_DATE): rd_data = t_date;
      ADDR_W'(OFS_MON):  rd_data = t_mon;
      ADDR_W'(OFS_YEAR): rd_data = t_year;
      default:           rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtc_calendar_checker.sv
module rtc_calendar_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic       adv,
  input logic       time_wr,
  input logic       alarm_en,
  input logic       alarm_hit,
  input logic [7:0] sec,
  input logic [7:0] min,
  input logic [7:0] hour,
  input logic [7:0] date
);
  assert_sec_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !time_wr && sec == 8'h59) |=> (sec == 8'h00));

  assert_pm_midnight_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !time_wr && hour == 8'hB1 && min == 8'h59 && sec == 8'h59) |=> (hour == 8'h92));

  assert_hit_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |-> alarm_en);

  assert_hit_follows_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |-> $past(adv));

  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !time_wr) |=> ($stable(sec) && $stable(min) && $stable(hour) && $stable(date)));
endmodule

bind rtc_calendar_core rtc_calendar_checker u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .adv(tick_adv), .time_wr(time_wr),
  .alarm_en(alarm_en), .alarm_hit(alarm_hit),
  .sec(t_sec), .min(t_min), .hour(t_hour), .date(t_date)
);

// File: tb/tb_rtc_calendar_core.sv
`timescale 1ns/1ps
module tb_rtc_calendar_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, run = 1'b1, alarm_en = 1'b0, wr_en = 1'b0;
  logic [5:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       alarm_hit;
  int         checks = 0, errors = 0;

  always #5 clk = ~clk;

  rtc_calendar_core dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .alarm_en(alarm_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .alarm_hit(alarm_hit)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [7:0] exp);
    rd_addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_hms(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(6'h22, h); wr(6'h21, m); wr(6'h20, s);
  endtask

  task automatic set_day(input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y);
    wr(6'h24, d); wr(6'h25, mo); wr(6'h26, y);
  endtask

  task automatic t_reset();
    rd_chk("R11 sec", 6'h20, 8'h00);
    rd_chk("R11 hour", 6'h22, 8'h00);
    rd_chk("R11 dow", 6'h23, 8'h01);
    rd_chk("R11 date", 6'h24, 8'h01);
    rd_chk("R11 month", 6'h25, 8'h01);
    rd_chk("R11 year", 6'h26, 8'h00);
    chk("R11 alarm_hit", {7'b0, alarm_hit}, 8'h00);
  endtask

  task automatic t_day_roll_24h();
    set_hms(8'h23, 8'h59, 8'h59);
    wr(6'h23, 8'h07);
    set_day(8'h15, 8'h03, 8'h20);
    pulse_tick();
    rd_chk("R1 sec wrap", 6'h20, 8'h00);
    rd_chk("R1 min wrap", 6'h21, 8'h00);
    rd_chk("R2 hour 23->00", 6'h22, 8'h00);
    rd_chk("R4 dow 07->01", 6'h23, 8'h01);
    rd_chk("R5 date 15->16", 6'h24, 8'h16);
    set_hms(8'h09, 8'h59, 8'h59);
    pulse_tick();
    rd_chk("R2 hour 09->10", 6'h22, 8'h10);
    rd_chk("R4 dow unchanged", 6'h23, 8'h01);
  endtask

  task automatic t_twelve_hour();
    set_day(8'h16, 8'h03, 8'h20);
    set_hms(8'hB1, 8'h59, 8'h59);
    pulse_tick();
    rd_chk("R3 11PM->12AM", 6'h22, 8'h92);
    rd_chk("R3 date advance", 6'h24, 8'h17);
    set_hms(8'h91, 8'h59, 8'h59);
    pulse_tick();
    rd_chk("R3 11AM->12PM", 6'h22, 8'hB2);
    rd_chk("R3 no date advance", 6'h24, 8'h17);
    set_hms(8'hB2, 8'h59, 8'h59);
    pulse_tick();
    rd_chk("R3 12PM->01PM", 6'h22, 8'hA1);
    set_hms(8'h89, 8'h59, 8'h59);
    pulse_tick();
    rd_chk("R3 09AM->10AM", 6'h22, 8'h90);
    wr(6'h22, 8'hC5);
    rd_chk("R6 hour bit6 reads 0", 6'h22, 8'h85);
  endtask

  task automatic month_case(input string tag, input logic [7:0] d, input logic [7:0] mo,
                            input logic [7:0] y, input logic [7:0] ed, input logic [7:0] emo,
                            input logic [7:0] ey);
    set_day(d, mo, y);
    set_hms(8'h23, 8'h59, 8'h59);
    pulse_tick();
    rd_chk({tag, " date"}, 6'h24, ed);
    rd_chk({tag, " month"}, 6'h25, emo);
    rd_chk({tag, " year"}, 6'h26, ey);
  endtask

  task automatic t_calendar();
    month_case("R5 feb28 nonleap", 8'h28, 8'h02, 8'h23, 8'h01, 8'h03, 8'h23);
    month_case("R5 feb28 leap", 8'h28, 8'h02, 8'h24, 8'h29, 8'h02, 8'h24);
    month_case("R5 feb29 leap", 8'h29, 8'h02, 8'h96, 8'h01, 8'h03, 8'h96);
    month_case("R5 apr30", 8'h30, 8'h04, 8'h10, 8'h01, 8'h05, 8'h10);
    month_case("R5 jan30", 8'h30, 8'h01, 8'h10, 8'h31, 8'h01, 8'h10);
    month_case("R5 dec31 y99", 8'h31, 8'h12, 8'h99, 8'h01, 8'h01, 8'h00);
  endtask

  task automatic t_address_map();
    wr(6'h28, 8'h45);
    rd_chk("R7 alarm sec write-only", 6'h28, 8'h00);
    rd_chk("R6 gap 27h", 6'h27, 8'h00);
    rd_chk("R6 alarm hour reads 0", 6'h2A, 8'h00);
    rd_chk("R6 outside map", 6'h10, 8'h00);
    wr(6'h20, 8'hD5);
    rd_chk("R6 sec bit7 reads 0", 6'h20, 8'h55);
    wr(6'h26, 8'h42);
    rd_chk("R6 year offset 6", 6'h26, 8'h42);
  endtask

  task automatic t_alarm();
    wr(6'h28, 8'h30); wr(6'h29, 8'h20); wr(6'h2A, 8'h10);
    alarm_en = 1'b1;
    set_hms(8'h10, 8'h20, 8'h29);
    chk("R8 write alone no hit", {7'b0, alarm_hit}, 8'h00);
    pulse_tick();
    chk("R8 hit after tick", {7'b0, alarm_hit}, 8'h01);
    @(negedge clk);
    chk("R8 hit one cycle", {7'b0, alarm_hit}, 8'h00);
    wr(6'h20, 8'h30);
    chk("R8 write into match no hit", {7'b0, alarm_hit}, 8'h00);
    @(negedge clk);
    chk("R8 write into match later", {7'b0, alarm_hit}, 8'h00);
    alarm_en = 1'b0;
    wr(6'h20, 8'h29);
    pulse_tick();
    chk("R8 disabled no hit", {7'b0, alarm_hit}, 8'h00);
    alarm_en = 1'b1;
    wr(6'h2A, 8'hE3);
    set_hms(8'hA3, 8'h20, 8'h29);
    pulse_tick();
    chk("R7 12h PM match, bits7:6 ignored", {7'b0, alarm_hit}, 8'h01);
    wr(6'h2A, 8'h03);
    wr(6'h20, 8'h29);
    pulse_tick();
    chk("R7 AM latch vs PM time", {7'b0, alarm_hit}, 8'h00);
    alarm_en = 1'b0;
  endtask

  task automatic t_freeze();
    set_hms(8'h05, 8'h10, 8'h59);
    run = 1'b0;
    pulse_tick();
    pulse_tick();
    rd_chk("R9 sec frozen", 6'h20, 8'h59);
    rd_chk("R9 min frozen", 6'h21, 8'h10);
    wr(6'h21, 8'h33);
    rd_chk("R9 write while stopped", 6'h21, 8'h33);
    run = 1'b1;
    pulse_tick();
    rd_chk("R9 resumes", 6'h20, 8'h00);
  endtask

  task automatic t_write_priority();
    set_hms(8'h07, 8'h05, 8'h59);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'h20; wr_data = 8'h30; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    rd_chk("R10 written sec wins", 6'h20, 8'h30);
    rd_chk("R10 min still carries", 6'h21, 8'h06);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_day_roll_24h();
    t_twelve_hour();
    t_calendar();
    t_address_map();
    t_alarm();
    t_freeze();
    t_write_priority();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule